// File: doc/BRIEF.md
# Oscillator Pair Comparison Response Generator

This block turns the frequency mismatch inside a bank of free-running ring oscillators into a single response bit. The caller presents a challenge and a mode, then pulses a start strobe. The block clears a per-oscillator edge counter for every oscillator in the bank. It lets every counter accumulate rising edges for a fixed window of system clock cycles. It then compares the counts that the challenge names. Each oscillator input is synchronized with two flops and turned into a one-cycle rising-edge pulse before it reaches its counter.

Three modes are accepted. In free mode, any two different oscillators can be compared. In adjacent mode, only physically neighbouring oscillators may be paired, which gives better stability at the cost of challenge space. In group mode, the challenge names a group of `GROUP_K` oscillators, and the block compares the fastest member against the slowest member of that group. The remaining members are ignored. A challenge that is illegal for its mode is refused with a one-cycle error pulse, and no evaluation starts.

Top module: `ro_pair_puf`

## Requirements
- R1: After reset, `busy_o`, `valid_o`, `err_o`, `resp_o` and `tie_o` are all 0.
- R2: The challenge holds two indices: `challenge_i[IDX_W-1:0]` is index A and `challenge_i[2*IDX_W-1:IDX_W]` is index B. In free mode (`mode_i`=0), the response is 1 exactly when oscillator A produced more rising edges in the window than oscillator B.
- R3: When the compared counts are equal, the response is 0 and `tie_o` is 1. Otherwise `tie_o` is 0.
- R4: In free or adjacent mode, a challenge whose two indices are equal causes `err_o` to go high for one cycle after the start edge. In that case `busy_o` and `valid_o` stay low.
- R5: Adjacent mode (`mode_i`=1) accepts only index pairs whose difference is exactly 1, in either order, with no wrap from the last index to the first. All other pairs are refused as in R4. The response rule is the same as in R2.
- R6: In group mode (`mode_i`=2), the group is index A divided by `GROUP_K`, and index B is ignored. Within the group, the member with the highest count and the member with the lowest count are found; ties go to the lowest index in both cases. The response is 1 when the highest-count member has the lower index. If all members of the group are equal, the response is 0 and `tie_o` is 1.
- R7: An accepted start raises `busy_o` on the following cycle. `busy_o` stays high for exactly `WIN_CYCLES`+1 cycles. `valid_o` is high for exactly one cycle, the first cycle after `busy_o` falls. `resp_o` and `tie_o` change only in that cycle.
- R8: A start strobe that arrives while `busy_o` is high has no effect on the running evaluation and does not start a new one.
- R9: Mode value 3 is reserved and is refused as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only while idle |
| mode_i | input | 2 | 0 free pair, 1 adjacent pair, 2 group extremes, 3 reserved |
| challenge_i | input | 2*IDX_W | Index B in the upper half, index A in the lower half |
| ro_i | input | NUM_RO | Free-running oscillator inputs, asynchronous to clk_i |
| resp_o | output | 1 | Response bit |
| tie_o | output | 1 | The compared counts were equal |
| valid_o | output | 1 | One-cycle pulse when a response is ready |
| busy_o | output | 1 | An evaluation is in progress |
| err_o | output | 1 | One-cycle pulse when a challenge is refused |

## Verification
The bench builds the block with 16 oscillators in two groups of 8, a 12-bit counter and a 2048-cycle window. This places every oscillator period between 60 ns and 210 ns far enough apart that the one-count jitter from the synchronizers cannot flip a comparison. With two groups, the group index derived from index A is exercised for both values. Oscillators that are held still give exactly equal counts, so ties can be tested both for a single pair and for a whole group. The adjacency test covers the top index, where a wrap to index 0 must be refused.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_ADJ   = 2'd1,
    MODE_GROUP = 2'd2,
    MODE_RSVD  = 2'd3
  } puf_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2
  } puf_state_e;
endpackage

// File: rtl/ro_edge_tap.sv
module ro_edge_tap #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ro_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [2:0]       sync_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ro_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  // saturating count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && rise && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ro_spread_finder.sv
module ro_spread_finder #(
  parameter int NUM_RO  = 16,
  parameter int GROUP_K = 8,
  parameter int CNT_W   = 16,
  localparam int NUM_GRP = NUM_RO / GROUP_K,
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int K_W     = (GROUP_K > 1) ? $clog2(GROUP_K) : 1
) (
  input  logic [NUM_RO*CNT_W-1:0] cnt_flat_i,
  input  logic [GRP_W-1:0]        grp_i,
  output logic [K_W-1:0]          fast_o,
  output logic [K_W-1:0]          slow_o,
  output logic                    all_eq_o
);
  logic [CNT_W-1:0] max_v, min_v, cur_v;
  int               base;

  always_comb begin
    base   = int'(grp_i) * GROUP_K;
    max_v  = cnt_flat_i[base*CNT_W +: CNT_W];
    min_v  = max_v;
    cur_v  = max_v;
    fast_o = '0;
    slow_o = '0;
    for (int j = 1; j < GROUP_K; j++) begin
      cur_v = cnt_flat_i[(base+j)*CNT_W +: CNT_W];
      if (cur_v > max_v) begin
        max_v  = cur_v;
        fast_o = K_W'(j);
      end
      if (cur_v < min_v) begin
        min_v  = cur_v;
        slow_o = K_W'(j);
      end
    end
    all_eq_o = (max_v == min_v);
  end
endmodule

// File: rtl/ro_pair_puf.sv
module ro_pair_puf
  import ro_puf_pkg::*;
#(
  parameter int NUM_RO     = 16,
  parameter int GROUP_K    = 8,
  parameter int CNT_W      = 16,
  parameter int WIN_CYCLES = 4096,
  localparam int IDX_W   = $clog2(NUM_RO),
  localparam int NUM_GRP = NUM_RO / GROUP_K,
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int K_W     = (GROUP_K > 1) ? $clog2(GROUP_K) : 1,
  localparam int WIN_W   = $clog2(WIN_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [2*IDX_W-1:0] challenge_i,
  input  logic [NUM_RO-1:0]  ro_i,
  output logic               resp_o,
  output logic               tie_o,
  output logic               valid_o,
  output logic               busy_o,
  output logic               err_o
);
  puf_state_e       state_q;
  puf_mode_e        mode_in, mode_q;
  logic [IDX_W-1:0] in_a, in_b, sel_a_q, sel_b_q;
  logic [WIN_W-1:0] win_q;
  logic             chal_ok, accept, reject, run_en;
  logic             resp_q, tie_q, valid_q, err_q;

  logic [NUM_RO*CNT_W-1:0] cnt_flat;

  assign mode_in = puf_mode_e'(mode_i);
  assign in_a    = challenge_i[IDX_W-1:0];
  assign in_b    = challenge_i[2*IDX_W-1:IDX_W];

  always_comb begin
    unique case (mode_in)
      MODE_FREE:  chal_ok = (in_a != in_b);
      MODE_ADJ:   chal_ok = ({1'b0, in_a} + 1'b1 == {1'b0, in_b}) ||
                            ({1'b0, in_b} + 1'b1 == {1'b0, in_a});
      MODE_GROUP: chal_ok = 1'b1;
      default:    chal_ok = 1'b0;
    endcase
  end

  assign accept = (state_q == ST_IDLE) && start_i && chal_ok;
  assign reject = (state_q == ST_IDLE) && start_i && !chal_ok;
  assign run_en = (state_q == ST_RUN);

  for (genvar g = 0; g < NUM_RO; g++) begin : g_tap
    ro_edge_tap #(.CNT_W(CNT_W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ro_i   (ro_i[g]),
      .clr_i  (accept),
      .en_i   (run_en),
      .cnt_o  (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  // pair path
  logic [CNT_W-1:0] cnt_a, cnt_b;
  assign cnt_a = cnt_flat[int'(sel_a_q)*CNT_W +: CNT_W];
  assign cnt_b = cnt_flat[int'(sel_b_q)*CNT_W +: CNT_W];

  // group path
  logic [GRP_W-1:0] grp;
  logic [K_W-1:0]   fast_idx, slow_idx;
  logic             grp_eq;
  assign grp = GRP_W'(int'(sel_a_q) / GROUP_K);

  ro_spread_finder #(
    .NUM_RO  (NUM_RO),
    .GROUP_K (GROUP_K),
    .CNT_W   (CNT_W)
  ) u_spread (
    .cnt_flat_i (cnt_flat),
    .grp_i      (grp),
    .fast_o     (fast_idx),
    .slow_o     (slow_idx),
    .all_eq_o   (grp_eq)
  );

  logic resp_calc, tie_calc;
  always_comb begin
    if (mode_q == MODE_GROUP) begin
      tie_calc  = grp_eq;
      resp_calc = !grp_eq && (fast_idx < slow_idx);
    end else begin
      tie_calc  = (cnt_a == cnt_b);
      resp_calc = (cnt_a > cnt_b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_FREE;
      sel_a_q <= '0;
      sel_b_q <= '0;
      win_q   <= '0;
      resp_q  <= 1'b0;
      tie_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= reject;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          mode_q  <= mode_in;
          sel_a_q <= in_a;
          sel_b_q <= in_b;
          win_q   <= '0;
        end
        ST_RUN: begin
          win_q <= win_q + 1'b1;
          if (win_q == WIN_W'(WIN_CYCLES - 1)) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          resp_q  <= resp_calc;
          tie_q   <= tie_calc;
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign resp_o  = resp_q;
  assign tie_o   = tie_q;
endmodule

// File: rtl/ro_pair_puf_chk.sv
module ro_pair_puf_chk #(
  parameter int WIN_CYCLES = 4096
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic resp_o,
  input logic tie_o,
  input logic valid_o,
  input logic busy_o,
  input logic err_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  a_r3_tie_forces_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_o |-> !resp_o);

  a_r4_err_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(start_i));

  a_r4_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !valid_o));

  a_r7_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(busy_o) && !busy_o));

  a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (valid_o && busy_len == WIN_CYCLES + 1));

  a_r7_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_len < WIN_CYCLES + 1));

  a_r7_resp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(resp_o) && $stable(tie_o)));
endmodule

bind ro_pair_puf ro_pair_puf_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .resp_o  (resp_o),
  .tie_o   (tie_o),
  .valid_o (valid_o),
  .busy_o  (busy_o),
  .err_o   (err_o)
);

// File: tb/ro_pair_puf_tb.sv
`timescale 1ns/1ps
module ro_pair_puf_tb;
  localparam int NRO = 16;
  localparam int K   = 8;
  localparam int CW  = 12;
  localparam int WIN = 2048;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [2*IW-1:0] challenge_i = '0;
  logic [NRO-1:0] ro_raw, hold = '0;
  logic          resp_o, tie_o, valid_o, busy_o, err_o;

  int checks = 0;
  int fails  = 0;
  int per [NRO];
  bit poke = 1'b0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NRO; g++) begin : g_osc
    logic osc = 1'b0;
    initial begin
      #(g * 7 + 1);
      forever begin
        #(per[g] / 2);
        osc = ~osc;
      end
    end
    assign ro_raw[g] = osc;
  end

  ro_pair_puf #(
    .NUM_RO(NRO), .GROUP_K(K), .CNT_W(CW), .WIN_CYCLES(WIN)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .challenge_i(challenge_i), .ro_i(ro_raw & ~hold),
    .resp_o(resp_o), .tie_o(tie_o), .valid_o(valid_o),
    .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rate(input int i);
    return hold[i] ? 0 : 100000 / per[i];
  endfunction

  function automatic bit refused(input int m, input int a, input int b);
    if (m == 3) return 1'b1;
    if (m == 2) return 1'b0;
    if (a == b) return 1'b1;
    if (m == 1 && !(a == b + 1 || b == a + 1)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model(input int m, input int a, input int b,
                       output bit r, output bit t);
    if (m == 2) begin
      int base = (a / K) * K;
      int fi = 0, si = 0;
      for (int j = 1; j < K; j++) begin
        if (rate(base + j) > rate(base + fi)) fi = j;
        if (rate(base + j) < rate(base + si)) si = j;
      end
      t = (rate(base + fi) == rate(base + si));
      r = !t && (fi < si);
    end else begin
      t = (rate(a) == rate(b));
      r = rate(a) > rate(b);
    end
  endtask

  task automatic run(input int m, input int a, input int b, input string req);
    bit er, exp_r, exp_t;
    int busy_n = 0, seen_v = 0;
    er = refused(m, a, b);
    model(m, a, b, exp_r, exp_t);
    repeat (20) @(negedge clk);
    mode_i      = 2'(m);
    challenge_i = {IW'(b), IW'(a)};
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (er) begin
      chk(err_o == 1'b1, req, "err_o", int'(err_o), 1);
      chk(busy_o == 1'b0, req, "busy_o on refusal", int'(busy_o), 0);
      for (int i = 0; i < 6; i++) begin
        if (valid_o || busy_o) seen_v++;
        @(negedge clk);
      end
      chk(seen_v == 0, req, "activity after refusal", seen_v, 0);
    end else begin
      chk(err_o == 1'b0, req, "err_o", int'(err_o), 0);
      while (busy_o === 1'b1) begin
        busy_n++;
        if (poke && busy_n == 100) begin
          mode_i = 2'd0; challenge_i = {IW'(a), IW'(b)}; start_i = 1'b1;
        end else start_i = 1'b0;
        @(negedge clk);
      end
      start_i = 1'b0;
      chk(busy_n == WIN + 1, "R7", "busy length", busy_n, WIN + 1);
      chk(valid_o == 1'b1, "R7", "valid after busy", int'(valid_o), 1);
      chk(resp_o == exp_r, req, "resp_o", int'(resp_o), int'(exp_r));
      chk(tie_o == exp_t, "R3", "tie_o", int'(tie_o), int'(exp_t));
      @(negedge clk);
      chk(valid_o == 1'b0, "R7", "valid one cycle", int'(valid_o), 0);
      if (poke) begin
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R8", "start while busy ignored", int'(busy_o), 0);
      end
    end
  endtask

  task automatic shuffle();
    for (int i = 0; i < NRO; i++) per[i] = 60 + 10 * i;
    for (int i = NRO - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int tmp = per[i];
      per[i] = per[j];
      per[j] = tmp;
    end
  endtask

  initial begin
    #(20 * 190000);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_0a77));
    for (int i = 0; i < NRO; i++) per[i] = 60 + 10 * i;
    repeat (5) @(negedge clk);
    chk(busy_o == 0 && valid_o == 0, "R1", "busy/valid in reset", int'({busy_o, valid_o}), 0);
    chk(err_o == 0 && resp_o == 0 && tie_o == 0, "R1", "err/resp/tie in reset",
        int'({err_o, resp_o, tie_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && valid_o == 0 && err_o == 0, "R1", "idle after reset",
        int'({busy_o, valid_o, err_o}), 0);

    // directed: ordered periods, index 0 fastest
    run(0, 0, 9, "R2");
    run(0, 12, 3, "R2");
    run(0, 5, 5, "R4");
    run(1, 7, 7, "R4");
    run(3, 1, 2, "R9");
    run(1, 5, 6, "R5");
    run(1, 11, 10, "R5");
    run(1, 2, 5, "R5");
    run(1, 15, 0, "R5");
    run(2, 3, 0, "R6");
    run(2, 9, 4, "R6");
    poke = 1'b1;
    run(0, 4, 2, "R8");
    poke = 1'b0;

    // reversed ordering in group 1 changes the winner side
    for (int i = 0; i < NRO; i++) per[i] = 210 - 10 * i;
    run(2, 8, 0, "R6");
    run(0, 13, 14, "R2");

    // held oscillators give equal zero counts
    hold = 16'h0018;
    run(0, 3, 4, "R3");
    run(0, 3, 6, "R2");
    hold = 16'hff00;
    run(2, 10, 0, "R6");
    hold = '0;

    // random mix
    for (int n = 0; n < 20; n++) begin
      int m, a, b;
      if (n % 4 == 0) shuffle();
      m = int'($urandom % 3);
      a = int'($urandom % NRO);
      if (m == 1) b = (a == NRO - 1) ? a - 1 : ((a == 0 || $urandom % 2) ? a + 1 : a - 1);
      else        b = int'($urandom % NRO);
      run(m, a, b, m == 2 ? "R6" : (m == 1 ? "R5" : "R2"));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule